// File: doc/BRIEF.md
# Card Host Control and Interrupt Register Block

This block is the register front end of an SD/MMC-style card host. A processor-side bus issues single-cycle 32-bit writes and combinational reads at word-aligned byte addresses. The block keeps the controller configuration: global control, card clock setup, bus width, block size, byte count, command argument and command word. It hands these to the card-side engines as plain outputs.

A command is started by writing the command word with its top bit set. The block then issues a single launch pulse toward the command engine. It keeps the start bit readable as 1 until the engine reports completion. Setting the clock-update-only flag in the same word sends nothing on the card bus. Instead the block copies the staged clock settings onto its clock outputs, waiting first for the data path to go idle if the wait-for-previous flag is also set. The three reset requests in the global control word behave the same way: each stays readable as 1 until the engine signals that the reset is done.

Completion and error events from the engines set bits in a raw status word, and software clears them by writing ones. A mask word selects which raw bits reach the masked view and the single interrupt line. The global interrupt enable gates that line.

Top module: `mmc_host_csr`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads 0 and every output is 0 until something is written or an event arrives.
- R2: In the global control word (offset 0x00), bits 0, 1 and 2 are reset requests. Writing 1 sets a request, writing 0 leaves it unchanged, and the request reads 1 on `rst_req_o` and in the register until its `rst_done_i` bit pulses. If a set and a done arrive together, the set wins. Bit 4 (interrupt enable) and bit 5 (DMA enable, on `dma_en_o`) are plain read/write bits. All other bits read 0.
- R3: A write to the command word (offset 0x18) while its bit 31 reads 0 is accepted. All 32 bits are stored and appear on `cmd_word_o`. If bit 31 is set and bit 21 is clear, `cmd_launch_o` is 1 for exactly the one cycle after the write. Bit 31 then reads 1 until a `cmd_done_i` pulse clears it. An accepted write with bit 31 clear only stores the word.
- R4: A write to the command word while bit 31 reads 1 is ignored. The read value and `cmd_word_o` do not change, and no launch pulse is issued.
- R5: An accepted command write with bits 31 and 21 set issues no launch pulse. If bit 13 is set, the block waits until `data_busy_i` is 0. If bit 13 is clear, it waits for nothing. At the first clock edge after the write where the wait is satisfied, `clk_div_o` and `clk_on_o` load the staged clock word and bit 31 clears. The `cmd_done_i` input has no effect on this kind of command.
- R6: The clock control word (offset 0x04) holds the divider in bits 15:0 and the clock-on flag in bit 16, and reads back what was written. Writing it does not change `clk_div_o` or `clk_on_o`.
- R7: The width word (offset 0x0C) uses code 0 for 1 bit, 1 for 4 bits and 2 for 8 bits, and drives `bus_width_o`. A write of code 3 is ignored. Block size (offset 0x10, low 16 bits kept), byte count (0x14) and argument (0x1C) read back what was written and drive their outputs.
- R8: The raw status word (offset 0x38) has these bits: 2 command done, 3 data over, 6 response CRC error, 7 data CRC error, 8 response timeout, 11 FIFO under/overrun, 13 start bit error, 14 auto command done and 15 end bit error. A 1 on one of these bits of `evt_i` sets the bit. Other bits of `evt_i` are ignored. Writing 1 to a bit clears it, and an event in the same cycle wins over the clear.
- R9: The mask word (offset 0x30) stores only the implemented status bit positions. The masked view (offset 0x34) reads raw AND mask.
- R10: `irq_o` is 1 exactly when the interrupt enable is 1 and at least one masked status bit is 1.
- R11: Address bits 1:0 are ignored. Reads of offsets with no register (0x08, 0x20 to 0x2C, 0x3C and above) return 0.
- R12: Writes to the masked view (offset 0x34) change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cmd_launch_o | output | 1 | One-cycle start pulse to the command engine |
| cmd_word_o | output | 32 | Current command word |
| cmd_arg_o | output | 32 | Command argument |
| blk_size_o | output | BLK_W | Block size |
| byte_cnt_o | output | 32 | Transfer byte count |
| bus_width_o | output | 2 | Card bus width code |
| clk_div_o | output | 16 | Active card clock divider |
| clk_on_o | output | 1 | Active card clock gate |
| dma_en_o | output | 1 | DMA enable |
| rst_req_o | output | 3 | Pending reset requests (soft, FIFO, DMA) |
| rst_done_i | input | 3 | Reset completion pulses, one per request |
| cmd_done_i | input | 1 | Command engine finished the current command |
| data_busy_i | input | 1 | Data path still busy with a previous transfer |
| evt_i | input | 32 | Status event pulses, one per raw bit position |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench covers the following corner cases.

- **Second command write while start is still 1.** A design that accepted it would overwrite the pending command or launch twice.
- **Clock update while the data path is busy, with and without the wait flag.** A design that got this wrong would reprogram the clock in the middle of a transfer, or hang waiting when it should not.
- **Reset request written back as 0.** A design that got this wrong would drop a pending reset early.
- **Width code 3.** A design that got this wrong would store a reserved code.
- **Event and write-one-to-clear on the same bit in the same cycle.** A design that let the clear win would lose an event.
- **Unimplemented status bit positions in the event input and the mask.** A design that kept them would raise spurious interrupts.
- **Writes to the read-only masked view.** A design that decoded it as the raw word would clear status.
- **Interrupt enable dropped while a masked bit is pending.** The line must follow the enable at once.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam int unsigned DIV_W      = 16;
  localparam int unsigned NRST       = 3;

  localparam int unsigned OFF_GCTRL  = 32'h00;
  localparam int unsigned OFF_CLK    = 32'h04;
  localparam int unsigned OFF_WIDTH  = 32'h0C;
  localparam int unsigned OFF_BLK    = 32'h10;
  localparam int unsigned OFF_BCNT   = 32'h14;
  localparam int unsigned OFF_CMD    = 32'h18;
  localparam int unsigned OFF_ARG    = 32'h1C;
  localparam int unsigned OFF_MASK   = 32'h30;
  localparam int unsigned OFF_MINT   = 32'h34;
  localparam int unsigned OFF_RAW    = 32'h38;

  localparam int unsigned GC_IE_BIT  = 4;
  localparam int unsigned GC_DMA_BIT = 5;

  localparam int unsigned CMD_GO_BIT    = 31;
  localparam int unsigned CMD_CLKUP_BIT = 21;
  localparam int unsigned CMD_WAIT_BIT  = 13;

  localparam int unsigned ST_CMD_DONE   = 2;
  localparam int unsigned ST_DATA_OVER  = 3;
  localparam int unsigned ST_RSP_CRC    = 6;
  localparam int unsigned ST_DAT_CRC    = 7;
  localparam int unsigned ST_RSP_TMO    = 8;
  localparam int unsigned ST_FIFO_RUN   = 11;
  localparam int unsigned ST_START_ERR  = 13;
  localparam int unsigned ST_AUTO_DONE  = 14;
  localparam int unsigned ST_END_ERR    = 15;

  localparam logic [31:0] ST_IMPL =
      (32'd1 << ST_CMD_DONE)  | (32'd1 << ST_DATA_OVER) |
      (32'd1 << ST_RSP_CRC)   | (32'd1 << ST_DAT_CRC)   |
      (32'd1 << ST_RSP_TMO)   | (32'd1 << ST_FIFO_RUN)  |
      (32'd1 << ST_START_ERR) | (32'd1 << ST_AUTO_DONE) |
      (32'd1 << ST_END_ERR);
endpackage

// File: rtl/hcr_gctrl.sv
module hcr_gctrl
  import hcr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [NRST-1:0] set_i,
  input  logic            ie_i,
  input  logic            dma_i,
  input  logic [NRST-1:0] done_i,
  output logic [NRST-1:0] pend_o,
  output logic            ie_o,
  output logic            dma_o
);
  logic ie_q, dma_q;

  for (genvar g = 0; g < NRST; g++) begin : g_rst
    logic pend_q, pend_d;
    always_comb begin
      pend_d = pend_q;
      if (done_i[g])            pend_d = 1'b0;
      if (wr_i && set_i[g])     pend_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
    end
    assign pend_o[g] = pend_q;

    // R2: a request is held until its done pulse
    p_rst_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !done_i[g]) |=> pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      dma_q <= 1'b0;
    end else if (wr_i) begin
      ie_q  <= ie_i;
      dma_q <= dma_i;
    end
  end
  assign ie_o  = ie_q;
  assign dma_o = dma_q;
endmodule

// File: rtl/hcr_cmd.sv
module hcr_cmd
  import hcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [31:0]      wdata_i,
  input  logic [DIV_W:0]   clkcfg_i,
  input  logic             cmd_done_i,
  input  logic             data_busy_i,
  output logic [31:0]      cmd_o,
  output logic             launch_o,
  output logic [DIV_W-1:0] clk_div_o,
  output logic             clk_on_o
);
  logic           go_q, go_d, launch_q, launch_d;
  logic           upd_q, upd_d, wait_q, wait_d;
  logic [30:0]    cmd_q, cmd_d;
  logic [DIV_W:0] clk_q, clk_d;
  logic           accept, upd_fire;

  always_comb begin
    accept   = wr_i && !go_q;
    upd_fire = upd_q && (!wait_q || !data_busy_i);
    go_d     = go_q;
    cmd_d    = cmd_q;
    upd_d    = upd_q;
    wait_d   = wait_q;
    clk_d    = clk_q;
    launch_d = 1'b0;
    if (accept) begin
      cmd_d = wdata_i[30:0];
      go_d  = wdata_i[CMD_GO_BIT];
      if (wdata_i[CMD_GO_BIT]) begin
        if (wdata_i[CMD_CLKUP_BIT]) begin
          upd_d  = 1'b1;
          wait_d = wdata_i[CMD_WAIT_BIT];
        end else begin
          launch_d = 1'b1;
        end
      end
    end else if (upd_fire) begin
      clk_d = clkcfg_i;
      go_d  = 1'b0;
      upd_d = 1'b0;
    end else if (go_q && !upd_q && cmd_done_i) begin
      go_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q     <= 1'b0;
      launch_q <= 1'b0;
      upd_q    <= 1'b0;
      wait_q   <= 1'b0;
      cmd_q    <= '0;
      clk_q    <= '0;
    end else begin
      go_q     <= go_d;
      launch_q <= launch_d;
      upd_q    <= upd_d;
      wait_q   <= wait_d;
      if (accept)   cmd_q <= cmd_d;
      if (upd_fire) clk_q <= clk_d;
    end
  end

  assign cmd_o     = {go_q, cmd_q};
  assign launch_o  = launch_q;
  assign clk_div_o = clk_q[DIV_W-1:0];
  assign clk_on_o  = clk_q[DIV_W];

  // R3: one launch pulse per accepted command
  p_launch_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_q |=> !launch_q);
  // R4: writes while pending do not touch the word
  p_pending_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && go_q) |=> ($stable(cmd_q) && !launch_q));
  // R5: waiting update keeps the clock outputs
  p_clk_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && wait_q && data_busy_i) |=> $stable(clk_q));
endmodule

// File: rtl/hcr_irq.sv
module hcr_irq
  import hcr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        mask_wr_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] evt_i,
  input  logic        ie_i,
  output logic [31:0] raw_o,
  output logic [31:0] mask_o,
  output logic        irq_o
);
  logic [31:0] raw_q, raw_d, mask_q, clr_vec;

  always_comb begin
    clr_vec = clr_i ? wdata_i : '0;
    raw_d   = (raw_q & ~clr_vec) | (evt_i & ST_IMPL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= raw_d;
      if (mask_wr_i) mask_q <= wdata_i & ST_IMPL;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = ie_i && |(raw_q & mask_q);

  // R8: written ones are cleared unless an event set them again
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((raw_q & $past(wdata_i) & ~$past(evt_i)) == 32'd0));
  // R10: line only with the enable
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ie_i);
endmodule

// File: rtl/mmc_host_csr.sv
module mmc_host_csr
  import hcr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BLK_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cmd_launch_o,
  output logic [31:0]       cmd_word_o,
  output logic [31:0]       cmd_arg_o,
  output logic [BLK_W-1:0]  blk_size_o,
  output logic [31:0]       byte_cnt_o,
  output logic [1:0]        bus_width_o,
  output logic [15:0]       clk_div_o,
  output logic              clk_on_o,
  output logic              dma_en_o,
  output logic [2:0]        rst_req_o,
  input  logic [2:0]        rst_done_i,
  input  logic              cmd_done_i,
  input  logic              data_busy_i,
  input  logic [31:0]       evt_i,
  output logic              irq_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [1:0]       rs_q;
  logic             rst_sync_n;
  logic [IDX_W-1:0] widx;
  logic             unused_addr_lsb;
  logic             we_gc, we_clk, we_wid, we_blk, we_bcnt, we_cmd, we_arg, we_mask, we_raw;
  logic [DIV_W:0]   clkcfg_q;
  logic [1:0]       width_q;
  logic [BLK_W-1:0] blk_q;
  logic [31:0]      bcnt_q, arg_q, raw_w, mask_w;
  logic [2:0]       pend_w;
  logic             ie_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign widx            = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];

  always_comb begin
    we_gc   = bus_we && (widx == IDX_W'(OFF_GCTRL >> 2));
    we_clk  = bus_we && (widx == IDX_W'(OFF_CLK   >> 2));
    we_wid  = bus_we && (widx == IDX_W'(OFF_WIDTH >> 2)) && (bus_wdata[1:0] != 2'd3);
    we_blk  = bus_we && (widx == IDX_W'(OFF_BLK   >> 2));
    we_bcnt = bus_we && (widx == IDX_W'(OFF_BCNT  >> 2));
    we_cmd  = bus_we && (widx == IDX_W'(OFF_CMD   >> 2));
    we_arg  = bus_we && (widx == IDX_W'(OFF_ARG   >> 2));
    we_mask = bus_we && (widx == IDX_W'(OFF_MASK  >> 2));
    we_raw  = bus_we && (widx == IDX_W'(OFF_RAW   >> 2));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      clkcfg_q <= '0;
      width_q  <= '0;
      blk_q    <= '0;
      bcnt_q   <= '0;
      arg_q    <= '0;
    end else begin
      if (we_clk)  clkcfg_q <= bus_wdata[DIV_W:0];
      if (we_wid)  width_q  <= bus_wdata[1:0];
      if (we_blk)  blk_q    <= bus_wdata[BLK_W-1:0];
      if (we_bcnt) bcnt_q   <= bus_wdata;
      if (we_arg)  arg_q    <= bus_wdata;
    end
  end

  hcr_gctrl u_gctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_i   (we_gc),
    .set_i  (bus_wdata[NRST-1:0]),
    .ie_i   (bus_wdata[GC_IE_BIT]),
    .dma_i  (bus_wdata[GC_DMA_BIT]),
    .done_i (rst_done_i),
    .pend_o (pend_w),
    .ie_o   (ie_w),
    .dma_o  (dma_en_o)
  );

  hcr_cmd u_cmd (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_i        (we_cmd),
    .wdata_i     (bus_wdata),
    .clkcfg_i    (clkcfg_q),
    .cmd_done_i  (cmd_done_i),
    .data_busy_i (data_busy_i),
    .cmd_o       (cmd_word_o),
    .launch_o    (cmd_launch_o),
    .clk_div_o   (clk_div_o),
    .clk_on_o    (clk_on_o)
  );

  hcr_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr_i     (we_raw),
    .mask_wr_i (we_mask),
    .wdata_i   (bus_wdata),
    .evt_i     (evt_i),
    .ie_i      (ie_w),
    .raw_o     (raw_w),
    .mask_o    (mask_w),
    .irq_o     (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if      (widx == IDX_W'(OFF_GCTRL >> 2)) bus_rdata = {26'd0, dma_en_o, ie_w, 1'b0, pend_w};
    else if (widx == IDX_W'(OFF_CLK   >> 2)) bus_rdata = 32'(clkcfg_q);
    else if (widx == IDX_W'(OFF_WIDTH >> 2)) bus_rdata = {30'd0, width_q};
    else if (widx == IDX_W'(OFF_BLK   >> 2)) bus_rdata = 32'(blk_q);
    else if (widx == IDX_W'(OFF_BCNT  >> 2)) bus_rdata = bcnt_q;
    else if (widx == IDX_W'(OFF_CMD   >> 2)) bus_rdata = cmd_word_o;
    else if (widx == IDX_W'(OFF_ARG   >> 2)) bus_rdata = arg_q;
    else if (widx == IDX_W'(OFF_MASK  >> 2)) bus_rdata = mask_w;
    else if (widx == IDX_W'(OFF_MINT  >> 2)) bus_rdata = raw_w & mask_w;
    else if (widx == IDX_W'(OFF_RAW   >> 2)) bus_rdata = raw_w;
  end

  assign rst_req_o   = pend_w;
  assign cmd_arg_o   = arg_q;
  assign blk_size_o  = blk_q;
  assign byte_cnt_o  = bcnt_q;
  assign bus_width_o = width_q;

  // R7: reserved width code never reaches the output
  p_width_legal_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_width_o != 2'd3);
  // R12: masked view is read-only
  p_mint_readonly_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && widx == IDX_W'(OFF_MINT >> 2) && evt_i == 32'd0) |=> $stable(raw_w));
endmodule

// File: tb/mmc_host_csr_bench.sv
module mmc_host_csr_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        cmd_launch_o;
  logic [31:0] cmd_word_o, cmd_arg_o, byte_cnt_o;
  logic [15:0] blk_size_o, clk_div_o;
  logic [1:0]  bus_width_o;
  logic        clk_on_o, dma_en_o, irq_o;
  logic [2:0]  rst_req_o, rst_done_i;
  logic        cmd_done_i, data_busy_i;
  logic [31:0] evt_i;

  int n_checks = 0;
  int n_err    = 0;

  always #10 clk = ~clk;

  mmc_host_csr u_mmc_host_csr (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_launch_o(cmd_launch_o),
    .cmd_word_o(cmd_word_o), .cmd_arg_o(cmd_arg_o), .blk_size_o(blk_size_o),
    .byte_cnt_o(byte_cnt_o), .bus_width_o(bus_width_o), .clk_div_o(clk_div_o),
    .clk_on_o(clk_on_o), .dma_en_o(dma_en_o), .rst_req_o(rst_req_o),
    .rst_done_i(rst_done_i), .cmd_done_i(cmd_done_i), .data_busy_i(data_busy_i),
    .evt_i(evt_i), .irq_o(irq_o)
  );

  // behavioural reference state
  localparam logic [31:0] IMPL = 32'h0000_E9CC;
  logic [2:0]  m_pend;
  logic        m_ie, m_dma, m_on, m_start, m_upd, m_wait, m_launch;
  logic [16:0] m_stage;
  logic [15:0] m_div, m_blk;
  logic [1:0]  m_width;
  logic [31:0] m_bcnt, m_arg, m_mask, m_raw;
  logic [30:0] m_cmd;
  int          sync_cnt = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a[7:2])
      6'd0:    return {26'd0, m_dma, m_ie, 1'b0, m_pend};
      6'd1:    return {15'd0, m_stage};
      6'd3:    return {30'd0, m_width};
      6'd4:    return {16'd0, m_blk};
      6'd5:    return m_bcnt;
      6'd6:    return {m_start, m_cmd};
      6'd7:    return m_arg;
      6'd12:   return m_mask;
      6'd13:   return m_raw & m_mask;
      6'd14:   return m_raw;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_clear();
    m_pend = '0; m_ie = 0; m_dma = 0; m_on = 0; m_start = 0; m_upd = 0;
    m_wait = 0; m_launch = 0; m_stage = '0; m_div = '0; m_blk = '0;
    m_width = '0; m_bcnt = '0; m_arg = '0; m_mask = '0; m_raw = '0; m_cmd = '0;
  endtask

  task automatic cyc();
    int wi;
    bit in_rst;
    logic [2:0]  n_pend;
    logic        n_ie, n_dma, n_on, n_start, n_upd, n_wait, n_launch;
    logic [16:0] n_stage;
    logic [15:0] n_div, n_blk;
    logic [1:0]  n_width;
    logic [31:0] n_bcnt, n_arg, n_mask, n_raw;
    logic [30:0] n_cmd;
    wi = int'(bus_addr[7:2]);
    in_rst = !rst_n || sync_cnt < 2;
    n_pend = (m_pend & ~rst_done_i);
    n_ie = m_ie; n_dma = m_dma;
    if (bus_we && wi == 0) begin
      n_pend = n_pend | bus_wdata[2:0];
      n_ie = bus_wdata[4]; n_dma = bus_wdata[5];
    end
    n_stage = (bus_we && wi == 1) ? bus_wdata[16:0] : m_stage;
    n_width = (bus_we && wi == 3 && bus_wdata[1:0] != 2'd3) ? bus_wdata[1:0] : m_width;
    n_blk   = (bus_we && wi == 4) ? bus_wdata[15:0] : m_blk;
    n_bcnt  = (bus_we && wi == 5) ? bus_wdata : m_bcnt;
    n_arg   = (bus_we && wi == 7) ? bus_wdata : m_arg;
    n_mask  = (bus_we && wi == 12) ? (bus_wdata & IMPL) : m_mask;
    n_raw   = (m_raw & ~((bus_we && wi == 14) ? bus_wdata : 32'd0)) | (evt_i & IMPL);
    n_cmd = m_cmd; n_start = m_start; n_upd = m_upd; n_wait = m_wait;
    n_div = m_div; n_on = m_on; n_launch = 0;
    if (bus_we && wi == 6 && !m_start) begin
      n_cmd = bus_wdata[30:0];
      n_start = bus_wdata[31];
      if (bus_wdata[31] && bus_wdata[21]) begin n_upd = 1; n_wait = bus_wdata[13]; end
      else if (bus_wdata[31]) n_launch = 1;
    end else if (m_upd && !(m_wait && data_busy_i)) begin
      n_div = m_stage[15:0]; n_on = m_stage[16]; n_start = 0; n_upd = 0;
    end else if (m_start && !m_upd && cmd_done_i) begin
      n_start = 0;
    end
    @(posedge clk);
    if (in_rst) model_clear();
    else begin
      m_pend = n_pend; m_ie = n_ie; m_dma = n_dma; m_stage = n_stage;
      m_width = n_width; m_blk = n_blk; m_bcnt = n_bcnt; m_arg = n_arg;
      m_mask = n_mask; m_raw = n_raw; m_cmd = n_cmd; m_start = n_start;
      m_upd = n_upd; m_wait = n_wait; m_div = n_div; m_on = n_on; m_launch = n_launch;
    end
    if (!rst_n) sync_cnt = 0; else if (sync_cnt < 2) sync_cnt++;
    #1;
    chk("R11", "rdata", bus_rdata, exp_rd(bus_addr));
    chk("R3", "launch", 32'(cmd_launch_o), 32'(m_launch));
    chk("R3", "cmd_word", cmd_word_o, {m_start, m_cmd});
    chk("R5", "clk_out", {15'd0, clk_on_o, clk_div_o}, {15'd0, m_on, m_div});
    chk("R2", "rst_req", 32'(rst_req_o), 32'(m_pend));
    chk("R2", "dma_en", 32'(dma_en_o), 32'(m_dma));
    chk("R7", "outs", {14'd0, bus_width_o, blk_size_o}, {14'd0, m_width, m_blk});
    chk("R7", "arg", cmd_arg_o ^ byte_cnt_o, m_arg ^ m_bcnt);
    chk("R10", "irq", 32'(irq_o), 32'(m_ie && |(m_raw & m_mask)));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    bus_addr = a;
    #1;
    chk(tag, "read", bus_rdata, e);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    model_clear();
    rst_n = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; rst_done_i = '0;
    cmd_done_i = 0; data_busy_i = 0; evt_i = '0;
    repeat (3) cyc();
    // R1: all registers zero in reset
    for (int a = 0; a < 64; a += 4) rd(8'(a), 32'd0, "R1");
    rst_n = 1;
    repeat (4) cyc();
    for (int a = 0; a < 64; a += 4) rd(8'(a), 32'd0, "R1");
    chk("R1", "irq", 32'(irq_o), 32'd0);

    // R2 reset requests
    wr(8'h00, 32'h37);      rd(8'h00, 32'h37, "R2");
    chk("R2", "rst_req", 32'(rst_req_o), 32'd7);
    rst_done_i = 3'b010; cyc(); rst_done_i = '0;
    rd(8'h00, 32'h35, "R2");
    wr(8'h00, 32'h00);      rd(8'h00, 32'h05, "R2");
    rst_done_i = 3'b101; cyc(); rst_done_i = '0;
    rd(8'h00, 32'h00, "R2");
    rst_done_i = 3'b001; wr(8'h00, 32'h11); rst_done_i = '0;
    rd(8'h00, 32'h11, "R2");
    rst_done_i = 3'b001; cyc(); rst_done_i = '0;
    rd(8'h00, 32'h10, "R2");

    // R6 / R5 clock staging and update
    wr(8'h04, 32'h0001_0004); rd(8'h04, 32'h0001_0004, "R6");
    chk("R6", "clk_div", 32'(clk_div_o), 32'd0);
    data_busy_i = 1;
    wr(8'h18, 32'h8020_2000);
    chk("R5", "no launch", 32'(cmd_launch_o), 32'd0);
    cmd_done_i = 1; cyc(); cmd_done_i = 0;
    repeat (2) cyc();
    rd(8'h18, 32'h8020_2000, "R5");
    chk("R5", "clk_div held", 32'(clk_div_o), 32'd0);
    data_busy_i = 0; cyc();
    chk("R5", "clk_div", 32'(clk_div_o), 32'd4);
    chk("R5", "clk_on", 32'(clk_on_o), 32'd1);
    rd(8'h18, 32'h0020_2000, "R5");
    data_busy_i = 1;
    wr(8'h04, 32'h0000_0010);
    wr(8'h18, 32'h8020_0000);
    cyc();
    chk("R5", "no-wait div", 32'(clk_div_o), 32'h10);
    chk("R5", "no-wait on", 32'(clk_on_o), 32'd0);
    data_busy_i = 0;

    // R3 / R4 commands
    wr(8'h18, 32'h8000_12C5);
    chk("R3", "launch", 32'(cmd_launch_o), 32'd1);
    rd(8'h18, 32'h8000_12C5, "R3");
    cyc();
    chk("R3", "launch gone", 32'(cmd_launch_o), 32'd0);
    wr(8'h18, 32'h8000_0011);
    chk("R4", "no launch", 32'(cmd_launch_o), 32'd0);
    rd(8'h18, 32'h8000_12C5, "R4");
    cmd_done_i = 1; cyc(); cmd_done_i = 0;
    rd(8'h18, 32'h0000_12C5, "R3");
    wr(8'h18, 32'h8000_0011);
    chk("R3", "relaunch", 32'(cmd_launch_o), 32'd1);
    cmd_done_i = 1; cyc(); cmd_done_i = 0;
    wr(8'h18, 32'h0000_0341);
    chk("R3", "no launch w/o start", 32'(cmd_launch_o), 32'd0);
    rd(8'h18, 32'h0000_0341, "R3");

    // R7 width and plain registers
    wr(8'h0C, 32'd1); rd(8'h0C, 32'd1, "R7");
    wr(8'h0C, 32'd2); rd(8'h0C, 32'd2, "R7");
    wr(8'h0C, 32'd3); rd(8'h0C, 32'd2, "R7");
    chk("R7", "width out", 32'(bus_width_o), 32'd2);
    wr(8'h0C, 32'd0); rd(8'h0C, 32'd0, "R7");
    wr(8'h10, 32'hFFFF_0200); rd(8'h10, 32'h0000_0200, "R7");
    wr(8'h14, 32'h0000_1000); rd(8'h14, 32'h0000_1000, "R7");
    wr(8'h1C, 32'hDEAD_BEEF); rd(8'h1C, 32'hDEAD_BEEF, "R7");

    // R8 / R9 / R10 / R12 status and interrupt
    wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, 32'h0000_E9CC, "R9");
    evt_i = 32'hFFFF_FFFF; cyc(); evt_i = '0;
    rd(8'h38, 32'h0000_E9CC, "R8");
    rd(8'h34, 32'h0000_E9CC, "R9");
    chk("R10", "irq on", 32'(irq_o), 32'd1);
    wr(8'h38, 32'h0000_0004); rd(8'h38, 32'h0000_E9C8, "R8");
    evt_i = 32'h8; wr(8'h38, 32'h0000_0008); evt_i = '0;
    rd(8'h38, 32'h0000_E9C8, "R8");
    wr(8'h34, 32'hFFFF_FFFF); rd(8'h38, 32'h0000_E9C8, "R12");
    wr(8'h30, 32'h0000_0100); rd(8'h34, 32'h0000_0100, "R9");
    wr(8'h00, 32'h00);
    chk("R10", "irq gated", 32'(irq_o), 32'd0);
    wr(8'h00, 32'h10);
    chk("R10", "irq back", 32'(irq_o), 32'd1);
    wr(8'h38, 32'h0000_0100); rd(8'h34, 32'd0, "R9");
    chk("R10", "irq clear", 32'(irq_o), 32'd0);
    wr(8'h38, 32'hFFFF_FFFF); rd(8'h38, 32'd0, "R8");

    // R11 unmapped and misaligned
    rd(8'h08, 32'd0, "R11"); rd(8'h20, 32'd0, "R11"); rd(8'h2C, 32'd0, "R11");
    rd(8'h3C, 32'd0, "R11"); rd(8'h40, 32'd0, "R11"); rd(8'hFC, 32'd0, "R11");
    rd(8'h1B, 32'h0000_0341, "R11");
    repeat (3) cyc();

    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule